// File: doc/BRIEF.md
# Legacy Keyboard/Mouse Interrupt Release and Numeric-Error Snooper

This block sits beside a simple I/O bus and watches its cycles. It does not claim or alter them. Every cycle still reaches the downstream bus. The block only reacts to two fixed port addresses.

It holds the mouse interrupt and the keyboard interrupt in latches. A read of the keyboard data port (60h) releases both latches. The block also raises an internal coprocessor-error interrupt (IRQ13) when the active-low floating-point error input asserts. A write to the coprocessor port (F0h) clears that interrupt. If the error input is still asserted at the time of that write, the same write also asserts an active-low "ignore numeric error" output.

The bus side is a pair of single-cycle strobes, `io_rd` and `io_wr`, with an address. The block has no data input, because the data value of an access never matters.

Top module: `legacy_irq_snoop`

## Requirements
- R1: With `mouse_en`=1, a 0→1 change of `mouse_irq_in` sets the mouse latch. `irq12_out` reads 1 in the cycle after that clock edge. It stays 1 after the input falls.
- R2: An `io_rd` strobe with `io_addr`=KBD_PORT (60h) clears the mouse latch, so `irq12_out`=0 in the following cycle. A clear and a new rising edge in the same cycle leave the latch clear.
- R3: A 0→1 change of `kbd_irq_in` sets `irq1_out` in the next cycle, and it holds there. An `io_rd` of KBD_PORT clears it in the next cycle.
- R4: With `mouse_en`=0, `irq12_out` equals `mouse_irq_in` combinationally, and the mouse latch does not set.
- R5: A 1→0 change of `fpu_err_n` sets `irq13_out` in the next cycle. An `io_wr` strobe with `io_addr`=FPE_PORT (F0h) clears it in the next cycle.
- R6: An `io_wr` of FPE_PORT while `fpu_err_n`=0 drives `numerr_ignore_n` to 0 in the next cycle. The same write with `fpu_err_n`=1 leaves it at 1.
- R7: `numerr_ignore_n` returns to 1 in the cycle after a clock edge that sees `fpu_err_n`=1.
- R8: No other access has any side effect on the outputs. This covers a write to KBD_PORT, a read of FPE_PORT, and a read or write of any other address.
- R9: While `rst_n`=0 at a clock edge, all latches clear. After that edge, `irq1_out`=0, `irq13_out`=0 and `numerr_ignore_n`=1, and `irq12_out`=0 when `mouse_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | ADDR_W | I/O address of the current access |
| io_rd | input | 1 | One-cycle read strobe |
| io_wr | input | 1 | One-cycle write strobe |
| mouse_en | input | 1 | 1 = latch the mouse interrupt; 0 = pass it through |
| mouse_irq_in | input | 1 | Mouse interrupt request from the controller |
| kbd_irq_in | input | 1 | Keyboard interrupt request from the controller |
| fpu_err_n | input | 1 | Floating-point error, active low |
| irq12_out | output | 1 | Mouse interrupt toward the host |
| irq1_out | output | 1 | Keyboard interrupt toward the host |
| irq13_out | output | 1 | Coprocessor-error interrupt |
| numerr_ignore_n | output | 1 | Ignore numeric error, active low |

## Verification
The bench builds the block with `ADDR_W`=8. At that width the whole address space is 256 values, so it can be swept in both directions. Before each access, the bench re-arms every latch. It then confirms that exactly one read address and exactly one write address have an effect. The port constants keep their defaults, so the sweep crosses both decoded ports and every near-miss address. Directed sequences then cover the same-cycle clear-versus-set case, the pass-through mode, and the error-input gating.

// File: rtl/lirq_pkg.sv
// Shared constants and types for the legacy interrupt snooper.
// Assumes port numbers fit in the smallest address width used (8 bits).
package lirq_pkg;
    localparam int unsigned DEF_ADDR_W   = 16;
    localparam int unsigned DEF_KBD_PORT = 'h60;
    localparam int unsigned DEF_FPE_PORT = 'hF0;

    // Decoded side-effect strobes, one cycle wide.
    typedef struct packed {
        logic rd_kbd;   // read of the keyboard data port
        logic wr_fpe;   // write of the coprocessor error port
    } lirq_hits_t;
endpackage

// File: rtl/lirq_decode.sv
// Address decoder: turns bus strobes into side-effect pulses.
// Assumes io_rd/io_wr are single-cycle strobes. Port 60h reacts only to
// reads and port F0h only to writes; all other combinations are ignored.
module lirq_decode
    import lirq_pkg::*;
#(
    parameter int unsigned ADDR_W   = DEF_ADDR_W,
    parameter int unsigned KBD_PORT = DEF_KBD_PORT,
    parameter int unsigned FPE_PORT = DEF_FPE_PORT
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    output lirq_hits_t        hits
);
    localparam logic [ADDR_W-1:0] KBD_A = ADDR_W'(KBD_PORT);
    localparam logic [ADDR_W-1:0] FPE_A = ADDR_W'(FPE_PORT);

    // Compare address and qualify with direction.
    always_comb begin
        hits.rd_kbd = io_rd && (io_addr == KBD_A);
        hits.wr_fpe = io_wr && (io_addr == FPE_A);
    end
endmodule

// File: rtl/lirq_edge_latch.sv
// Edge-set / strobe-clear latch. Detects the assertion edge of sig_in
// (polarity chosen by ACTIVE_LOW) and holds it until clr. The clear has
// priority over a set in the same cycle. Assumes sig_in is synchronous.
module lirq_edge_latch #(
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    input  logic arm,
    input  logic clr,
    output logic q
);
    logic prev;
    logic edge_seen;

    // Pick the edge detector for the configured polarity.
    generate
        if (ACTIVE_LOW) begin : g_fall
            assign edge_seen = prev & ~sig_in;
        end else begin : g_rise
            assign edge_seen = ~prev & sig_in;
        end
    endgenerate

    // Remember the previous input level; reset to the idle level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= ACTIVE_LOW;
        else        prev <= sig_in;
    end

    // Hold the latched request; clear wins over set.
    always_ff @(posedge clk) begin
        if (!rst_n)                q <= 1'b0;
        else if (clr)              q <= 1'b0;
        else if (arm && edge_seen) q <= 1'b1;
    end
endmodule

// File: rtl/lirq_fperr.sv
// Coprocessor error path: raises IRQ13 on assertion of the active-low
// error input and clears it on a write strobe. The same write also sets
// the ignore flag, but only while the error input is low. The flag drops
// once the error input is seen high.
module lirq_fperr (
    input  logic clk,
    input  logic rst_n,
    input  logic fpu_err_n,
    input  logic wr_fpe,
    output logic irq13,
    output logic ignore_n
);
    logic ign_q;

    lirq_edge_latch #(.ACTIVE_LOW(1'b1)) u_irq13 (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (fpu_err_n),
        .arm    (1'b1),
        .clr    (wr_fpe),
        .q      (irq13)
    );

    // Ignore flag: set by gated write, cleared when the error goes away.
    always_ff @(posedge clk) begin
        if (!rst_n)         ign_q <= 1'b0;
        else if (fpu_err_n) ign_q <= 1'b0;
        else if (wr_fpe)    ign_q <= 1'b1;
    end

    assign ignore_n = ~ign_q;
endmodule

// File: rtl/legacy_irq_snoop.sv
// Top: snoops I/O cycles for the keyboard data port and the coprocessor
// error port and drives the legacy interrupt side-band signals. Bus
// cycles are never claimed; downstream forwarding is outside this block.
module legacy_irq_snoop
    import lirq_pkg::*;
#(
    parameter int unsigned ADDR_W   = DEF_ADDR_W,
    parameter int unsigned KBD_PORT = DEF_KBD_PORT,
    parameter int unsigned FPE_PORT = DEF_FPE_PORT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic              mouse_en,
    input  logic              mouse_irq_in,
    input  logic              kbd_irq_in,
    input  logic              fpu_err_n,
    output logic              irq12_out,
    output logic              irq1_out,
    output logic              irq13_out,
    output logic              numerr_ignore_n
);
    lirq_hits_t hits;
    logic       mouse_q;

    lirq_decode #(
        .ADDR_W(ADDR_W), .KBD_PORT(KBD_PORT), .FPE_PORT(FPE_PORT)
    ) u_dec (
        .io_addr (io_addr),
        .io_rd   (io_rd),
        .io_wr   (io_wr),
        .hits    (hits)
    );

    lirq_edge_latch #(.ACTIVE_LOW(1'b0)) u_mouse (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (mouse_irq_in),
        .arm    (mouse_en),
        .clr    (hits.rd_kbd),
        .q      (mouse_q)
    );

    lirq_edge_latch #(.ACTIVE_LOW(1'b0)) u_kbd (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (kbd_irq_in),
        .arm    (1'b1),
        .clr    (hits.rd_kbd),
        .q      (irq1_out)
    );

    lirq_fperr u_fpe (
        .clk      (clk),
        .rst_n    (rst_n),
        .fpu_err_n(fpu_err_n),
        .wr_fpe   (hits.wr_fpe),
        .irq13    (irq13_out),
        .ignore_n (numerr_ignore_n)
    );

    // Mouse output: latched in enabled mode, raw pass-through otherwise.
    assign irq12_out = mouse_en ? mouse_q : mouse_irq_in;
endmodule

// File: rtl/lirq_checker.sv
// Property checker for legacy_irq_snoop, attached by bind below.
// Decodes the ports on its own from the bus inputs.
module lirq_checker #(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned KBD_PORT = 'h60,
    parameter int unsigned FPE_PORT = 'hF0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_rd,
    input logic              io_wr,
    input logic              mouse_en,
    input logic              mouse_irq_in,
    input logic              fpu_err_n,
    input logic              irq12_out,
    input logic              irq1_out,
    input logic              irq13_out,
    input logic              numerr_ignore_n
);
    logic rd60, wrf0;
    assign rd60 = io_rd && (io_addr == ADDR_W'(KBD_PORT));
    assign wrf0 = io_wr && (io_addr == ADDR_W'(FPE_PORT));

    AST_RD_RELEASES_MOUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd60 |=> (!mouse_en || !irq12_out));                           // R2
    AST_RD_RELEASES_KBD: assert property (@(posedge clk) disable iff (!rst_n)
        rd60 |=> !irq1_out);                                           // R3
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !mouse_en |-> (irq12_out == mouse_irq_in));                    // R4
    AST_WR_CLEARS_IRQ13: assert property (@(posedge clk) disable iff (!rst_n)
        wrf0 |=> !irq13_out);                                          // R5
    AST_IGNORE_ON_ERR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wrf0 && !fpu_err_n) |=> !numerr_ignore_n);                    // R6
    AST_IGNORE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        fpu_err_n |=> numerr_ignore_n);                                // R7
endmodule

bind legacy_irq_snoop lirq_checker #(
    .ADDR_W(ADDR_W), .KBD_PORT(KBD_PORT), .FPE_PORT(FPE_PORT)
) u_lirq_chk (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .mouse_en(mouse_en), .mouse_irq_in(mouse_irq_in), .fpu_err_n(fpu_err_n),
    .irq12_out(irq12_out), .irq1_out(irq1_out), .irq13_out(irq13_out),
    .numerr_ignore_n(numerr_ignore_n)
);

// File: tb/test_legacy_irq_snoop.sv
module test_legacy_irq_snoop;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] io_addr = '0;
    logic          io_rd = 1'b0, io_wr = 1'b0;
    logic          mouse_en = 1'b1, mouse_irq_in = 1'b0, kbd_irq_in = 1'b0;
    logic          fpu_err_n = 1'b1;
    logic          irq12_out, irq1_out, irq13_out, numerr_ignore_n;
    int            checks = 0, errors = 0;
    bit            done = 1'b0;

    legacy_irq_snoop #(.ADDR_W(AW)) i_legacy_irq_snoop (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .mouse_en(mouse_en), .mouse_irq_in(mouse_irq_in), .kbd_irq_in(kbd_irq_in),
        .fpu_err_n(fpu_err_n), .irq12_out(irq12_out), .irq1_out(irq1_out),
        .irq13_out(irq13_out), .numerr_ignore_n(numerr_ignore_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    // Set mouse, keyboard and IRQ13 latches; leaves fpu_err_n low.
    task automatic arm_all();
        fpu_err_n = 1'b1; step();
        mouse_irq_in = 1'b1; kbd_irq_in = 1'b1; fpu_err_n = 1'b0; step();
        mouse_irq_in = 1'b0; kbd_irq_in = 1'b0; step();
    endtask

    task automatic access(input logic [AW-1:0] a, input logic rd);
        io_addr = a; io_rd = rd; io_wr = !rd; step();
        io_rd = 1'b0; io_wr = 1'b0;
    endtask

    initial begin
        repeat (3) step();
        // R9: reset state
        chk("R9 irq12", irq12_out, 1'b0);
        chk("R9 irq1", irq1_out, 1'b0);
        chk("R9 irq13", irq13_out, 1'b0);
        chk("R9 ignore_n", numerr_ignore_n, 1'b1);
        rst_n = 1'b1; step();

        // R1: set and hold after input falls
        mouse_irq_in = 1'b1; step();
        chk("R1 set", irq12_out, 1'b1);
        mouse_irq_in = 1'b0; step(); step();
        chk("R1 hold", irq12_out, 1'b1);

        // R2: clear wins over simultaneous rising edge
        mouse_irq_in = 1'b1; io_addr = 8'h60; io_rd = 1'b1; step();
        io_rd = 1'b0;
        chk("R2 clear wins", irq12_out, 1'b0);
        mouse_irq_in = 1'b0; step();

        // R4: pass-through, latch stays clear
        mouse_en = 1'b0; #1;
        chk("R4 low", irq12_out, 1'b0);
        mouse_irq_in = 1'b1; #1;
        chk("R4 high", irq12_out, 1'b1);
        step(); mouse_irq_in = 1'b0; #1;
        chk("R4 follows", irq12_out, 1'b0);
        mouse_en = 1'b1; #1;
        chk("R4 no latch", irq12_out, 1'b0);

        // R6: write with error inactive has no effect
        fpu_err_n = 1'b1; step();
        access(8'hF0, 1'b0);
        chk("R6 gated", numerr_ignore_n, 1'b1);

        // R5/R6/R7: error sequence
        fpu_err_n = 1'b0; step();
        chk("R5 set", irq13_out, 1'b1);
        access(8'hF0, 1'b0);
        chk("R5 clear", irq13_out, 1'b0);
        chk("R6 assert", numerr_ignore_n, 1'b0);
        step();
        chk("R6 held", numerr_ignore_n, 1'b0);
        fpu_err_n = 1'b1; step();
        chk("R7 drop", numerr_ignore_n, 1'b1);

        // R2/R3/R5/R6/R8: sweep every address in both directions
        for (int a = 0; a < 256; a++) begin
            for (int d = 0; d < 2; d++) begin
                logic rd;
                logic kbd_hit, fpe_hit;
                rd = (d == 0);
                kbd_hit = rd && (a == 'h60);
                fpe_hit = !rd && (a == 'hF0);
                arm_all();
                access(AW'(a), rd);
                chk("R2/R8 sweep irq12", irq12_out, !kbd_hit);
                chk("R3/R8 sweep irq1", irq1_out, !kbd_hit);
                chk("R5/R8 sweep irq13", irq13_out, !fpe_hit);
                chk("R6/R8 sweep ignore", numerr_ignore_n, !fpe_hit);
            end
        end

        // R9: reset clears armed latches
        arm_all();
        rst_n = 1'b0; step();
        chk("R9 rst irq12", irq12_out, 1'b0);
        chk("R9 rst irq1", irq1_out, 1'b0);
        chk("R9 rst irq13", irq13_out, 1'b0);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule